// File: doc/BRIEF.md
# Integer ALU with Set-Less-Than

This block is the arithmetic-logic unit for a simple load/store RISC datapath. It is purely combinational. One operand comes from a register. The second operand comes from a register or from a 16-bit constant that the block widens to 32 bits. A 4-bit operation code selects the function. The block returns a 32-bit result and a flag that marks an all-zero result, which branch-equal logic reads after a subtract.

The unit adds, subtracts, performs bitwise AND/OR/XOR, shifts left by a 5-bit amount, and does signed and unsigned less-than compares. It also builds an upper-immediate word. Add and subtract wrap around with no trap. The datapath subtracts a constant by adding a negative immediate, so immediates are sign-extended for the arithmetic and compare codes and zero-extended for the bitwise codes. The block has no stream traffic and no state, so every pin is a plain level. The result follows the inputs within the same cycle.

Top module: `alu_core`

## Requirements
- R1: With op_sel = 0 (add), result equals operand A plus operand B modulo 2^32, and no overflow indication exists.
- R2: With op_sel = 1 (subtract), result equals A minus B modulo 2^32, so equal operands give zero.
- R3: With op_sel = 2, 3 or 4, result is the bitwise AND, OR or XOR of A and B, in that order of codes.
- R4: With op_sel = 5, result is src_a shifted left by shamt (0 to 31), and the vacated low bits are filled with zeros.
- R5: With op_sel = 6, result is 1 when A < B as two's-complement numbers, else 0. For example, 0xFFFFFFFF versus 0x00000001 gives 1.
- R6: With op_sel = 7, result is 1 when A < B as unsigned numbers, else 0. For example, 0xFFFFFFFF versus 0x00000001 gives 0.
- R7: With op_sel = 8, result is imm_val in bits 31..16 with bits 15..0 forced to zero, independent of src_a, src_b and imm_en.
- R8: When imm_en = 1, operand B is imm_val instead of src_b. It is sign-extended for codes 0, 1, 6 and 7 and zero-extended for codes 2, 3 and 4. When imm_en = 0, operand B is src_b.
- R9: zero is 1 exactly when the 32-bit result is all zeros.
- R10: Op codes 9 to 15 are undefined and give result 0, with zero = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation code (0 add … 8 upper-immediate) |
| src_a | input | 32 | First operand |
| src_b | input | 32 | Register form of the second operand |
| imm_val | input | 16 | Immediate constant |
| imm_en | input | 1 | Use the widened immediate as the second operand |
| shamt | input | 5 | Left shift distance |
| result | output | 32 | Operation result |
| zero | output | 1 | Result-is-zero flag |

## Verification
The bench compares 0xFFFFFFFF against 1 under both compare codes. A design that used one comparator for both would return the same answer twice. It checks the 0x8000 immediate under add and under OR, where a wrong choice of widening shows up in the upper 16 bits. Add and subtract are checked at wrap-around values such as 0xFFFFFFFF + 1, where an overflow-sensitive path would return a nonzero value or a wrong zero flag. Shifts by 0 and by 31 are also checked, as is the upper-immediate code with nonzero register operands to catch leakage into the low half. Random operands across all sixteen codes exercise the undefined codes as well.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_SLL  = 4'd5,
    OP_SLT  = 4'd6,
    OP_SLTU = 4'd7,
    OP_LUI  = 4'd8
  } alu_op_e;
endpackage

// File: rtl/alu_opb_mux.sv
module alu_opb_mux #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [DATA_W-1:0] src_b,
  input  logic [IMM_W-1:0]  imm_val,
  input  logic              imm_en,
  input  logic              sign_ext,
  output logic [DATA_W-1:0] opb
);
  localparam int EXT_W = DATA_W - IMM_W;

  logic [EXT_W-1:0] ext_bits;

  assign ext_bits = sign_ext ? {EXT_W{imm_val[IMM_W-1]}} : '0;
  assign opb      = imm_en ? {ext_bits, imm_val} : src_b;
endmodule

// File: rtl/alu_arith.sv
module alu_arith #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub_en,
  output logic [DATA_W-1:0] sum,
  output logic              lt_s,
  output logic              lt_u
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   wide;

  assign b_eff = sub_en ? ~b : b;
  assign wide  = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub_en};
  assign sum   = wide[DATA_W-1:0];
  // borrow out of A - B means A < B unsigned
  assign lt_u  = ~wide[DATA_W];
  // signs differ: negative side is smaller; otherwise difference sign decides
  assign lt_s  = (a[MSB] ^ b[MSB]) ? a[MSB] : wide[MSB];
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int DATA_W = 32,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [SH_W-1:0]   shamt,
  output logic [DATA_W-1:0] and_r,
  output logic [DATA_W-1:0] or_r,
  output logic [DATA_W-1:0] xor_r,
  output logic [DATA_W-1:0] sll_r
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign and_r[i] = a[i] & b[i];
    assign or_r[i]  = a[i] | b[i];
    assign xor_r[i] = a[i] ^ b[i];
  end

  // logarithmic left shifter, one stage per shamt bit
  logic [DATA_W-1:0] stage [SH_W+1];
  assign stage[0] = a;
  for (genvar s = 0; s < SH_W; s++) begin : g_shift
    assign stage[s+1] = shamt[s] ? {stage[s][DATA_W-1-(1<<s):0], {(1<<s){1'b0}}}
                                 : stage[s];
  end
  assign sll_r = stage[SH_W];
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input  logic [OP_W-1:0]   op_sel,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [IMM_W-1:0]  imm_val,
  input  logic              imm_en,
  input  logic [SH_W-1:0]   shamt,
  output logic [DATA_W-1:0] result,
  output logic              zero
);
  localparam int PAD_W = DATA_W - IMM_W;

  alu_op_e           op;
  logic              sign_ext;
  logic              sub_en;
  logic [DATA_W-1:0] opb;
  logic [DATA_W-1:0] sum;
  logic              lt_s, lt_u;
  logic [DATA_W-1:0] and_r, or_r, xor_r, sll_r;

  assign op       = alu_op_e'(op_sel);
  assign sign_ext = (op == OP_ADD) || (op == OP_SUB) || (op == OP_SLT) || (op == OP_SLTU);
  assign sub_en   = (op == OP_SUB) || (op == OP_SLT) || (op == OP_SLTU);

  alu_opb_mux #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opb (
    .src_b(src_b), .imm_val(imm_val), .imm_en(imm_en),
    .sign_ext(sign_ext), .opb(opb)
  );

  alu_arith #(.DATA_W(DATA_W)) u_arith (
    .a(src_a), .b(opb), .sub_en(sub_en),
    .sum(sum), .lt_s(lt_s), .lt_u(lt_u)
  );

  alu_logic #(.DATA_W(DATA_W), .SH_W(SH_W)) u_logic (
    .a(src_a), .b(opb), .shamt(shamt),
    .and_r(and_r), .or_r(or_r), .xor_r(xor_r), .sll_r(sll_r)
  );

  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB: result = sum;
      OP_AND:         result = and_r;
      OP_OR:          result = or_r;
      OP_XOR:         result = xor_r;
      OP_SLL:         result = sll_r;
      OP_SLT:         result = {{(DATA_W-1){1'b0}}, lt_s};
      OP_SLTU:        result = {{(DATA_W-1){1'b0}}, lt_u};
      OP_LUI:         result = {imm_val, {PAD_W{1'b0}}};
      default:        result = '0;
    endcase
  end

  assign zero = ~|result;
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
  parameter int DATA_W = 32,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input logic [3:0]        op_sel,
  input logic [DATA_W-1:0] src_a,
  input logic [DATA_W-1:0] src_b,
  input logic              imm_en,
  input logic [SH_W-1:0]   shamt,
  input logic [DATA_W-1:0] result,
  input logic              zero
);
  logic [DATA_W-1:0] low_mask;
  assign low_mask = ({{(DATA_W-1){1'b0}}, 1'b1} << shamt) - {{(DATA_W-1){1'b0}}, 1'b1};

  always_comb begin
    AST_SUB_SELF_ZERO: assert (!(op_sel == 4'd1 && !imm_en && src_a == src_b) || zero) else $error("sub self"); // R2
    AST_SLL_LOW_CLEAR: assert (!(op_sel == 4'd5) || ((result & low_mask) == '0)) else $error("sll fill"); // R4
    AST_SLT_IS_BOOL: assert (!(op_sel == 4'd6 || op_sel == 4'd7) || (result[DATA_W-1:1] == '0)) else $error("slt width"); // R5
    AST_SLTU_NOT_LESS: assert (!(op_sel == 4'd7 && !imm_en && src_a >= src_b) || (result == '0)) else $error("sltu"); // R6
    AST_LUI_LOW_CLEAR: assert (!(op_sel == 4'd8) || (result[15:0] == 16'h0)) else $error("lui low"); // R7
    AST_UNDEF_OP_ZERO: assert (!(op_sel > 4'd8) || (zero && result == '0)) else $error("undef op"); // R10
  end
endmodule

bind alu_core alu_core_chk #(.DATA_W(DATA_W), .SH_W(SH_W)) u_chk (
  .op_sel(op_sel), .src_a(src_a), .src_b(src_b), .imm_en(imm_en),
  .shamt(shamt), .result(result), .zero(zero)
);

// File: tb/alu_core_tb_top.sv
module alu_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op_sel = '0;
  logic [31:0] src_a = '0, src_b = '0;
  logic [15:0] imm_val = '0;
  logic        imm_en = 1'b0;
  logic [4:0]  shamt = '0;
  logic [31:0] result;
  logic        zero;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  alu_core dut_i (
    .op_sel(op_sel), .src_a(src_a), .src_b(src_b), .imm_val(imm_val),
    .imm_en(imm_en), .shamt(shamt), .result(result), .zero(zero)
  );

  function automatic string tag_of(logic [3:0] op);
    case (op)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2, 4'd3, 4'd4: return "R3";
      4'd5: return "R4";
      4'd6: return "R5";
      4'd7: return "R6";
      4'd8: return "R7";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [31:0] ref_opb(logic [3:0] op, logic [31:0] b, logic [15:0] imm, logic ie);
    if (!ie) return b; // R8
    if (op == 4'd0 || op == 4'd1 || op == 4'd6 || op == 4'd7)
      return {{16{imm[15]}}, imm};
    return {16'h0, imm};
  endfunction

  function automatic logic [31:0] ref_result(logic [3:0] op, logic [31:0] a, logic [31:0] b,
                                             logic [15:0] imm, logic ie, logic [4:0] sh);
    logic [31:0] bb;
    bb = ref_opb(op, b, imm, ie);
    case (op)
      4'd0: return a + bb;
      4'd1: return a - bb;
      4'd2: return a & bb;
      4'd3: return a | bb;
      4'd4: return a ^ bb;
      4'd5: return a << sh;
      4'd6: return ($signed(a) < $signed(bb)) ? 32'd1 : 32'd0;
      4'd7: return (a < bb) ? 32'd1 : 32'd0;
      4'd8: return {imm, 16'h0};
      default: return 32'd0;
    endcase
  endfunction

  task automatic run(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                     input logic [15:0] imm, input logic ie, input logic [4:0] sh, input string tag);
    logic [31:0] exp_r;
    @(posedge clk);
    #2;
    op_sel = op; src_a = a; src_b = b; imm_val = imm; imm_en = ie; shamt = sh;
    #6;
    exp_r = ref_result(op, a, b, imm, ie, sh);
    checks++;
    if (result !== exp_r) begin
      errors++;
      $display("FAIL %s op=%0d result actual=%h expected=%h", tag, op, result, exp_r);
    end
    checks++;
    if (zero !== (exp_r == 32'd0)) begin
      errors++;
      $display("FAIL R9 (%s) zero actual=%b expected=%b", tag, zero, exp_r == 32'd0);
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    // idle inputs: add 0+0 -> 0, zero flag set (R1, R9)
    run(4'd0, 32'h0, 32'h0, 16'h0, 1'b0, 5'd0, "R1");
    // wrap-around add and subtract (R1, R2)
    run(4'd0, 32'hFFFF_FFFF, 32'h1, 16'h0, 1'b0, 5'd0, "R1");
    run(4'd1, 32'h0, 32'h1, 16'h0, 1'b0, 5'd0, "R2");
    run(4'd1, 32'h1234_5678, 32'h1234_5678, 16'h0, 1'b0, 5'd0, "R2");
    // bitwise (R3)
    run(4'd2, 32'hF0F0_A5A5, 32'hFF00_0FF0, 16'h0, 1'b0, 5'd0, "R3");
    run(4'd3, 32'hF0F0_A5A5, 32'h0F0F_0000, 16'h0, 1'b0, 5'd0, "R3");
    run(4'd4, 32'hAAAA_5555, 32'hAAAA_5555, 16'h0, 1'b0, 5'd0, "R3");
    // shift by 0 and 31 (R4)
    run(4'd5, 32'h8000_0003, 32'h0, 16'h0, 1'b0, 5'd0, "R4");
    run(4'd5, 32'h0000_0003, 32'h0, 16'h0, 1'b0, 5'd31, "R4");
    // signed vs unsigned compare of the same patterns (R5, R6)
    run(4'd6, 32'hFFFF_FFFF, 32'h1, 16'h0, 1'b0, 5'd0, "R5");
    run(4'd7, 32'hFFFF_FFFF, 32'h1, 16'h0, 1'b0, 5'd0, "R6");
    run(4'd6, 32'h1, 32'hFFFF_FFFF, 16'h0, 1'b0, 5'd0, "R5");
    run(4'd7, 32'h1, 32'hFFFF_FFFF, 16'h0, 1'b0, 5'd0, "R6");
    // upper immediate ignores register operands (R7)
    run(4'd8, 32'hDEAD_BEEF, 32'hFFFF_FFFF, 16'h003D, 1'b0, 5'd7, "R7");
    run(4'd8, 32'hDEAD_BEEF, 32'hFFFF_FFFF, 16'h8001, 1'b1, 5'd0, "R7");
    // immediate widening (R8): sign for add/compare, zero for OR
    run(4'd0, 32'h0000_0010, 32'h0, 16'hFFFF, 1'b1, 5'd0, "R8");
    run(4'd0, 32'h0, 32'h0, 16'h8000, 1'b1, 5'd0, "R8");
    run(4'd3, 32'h0, 32'h0, 16'h8000, 1'b1, 5'd0, "R8");
    run(4'd6, 32'h0, 32'hFFFF_FFFF, 16'hFFFF, 1'b1, 5'd0, "R8");
    run(4'd7, 32'h0000_FFFF, 32'h0, 16'hFFFF, 1'b1, 5'd0, "R8");
    // undefined codes (R10)
    run(4'd9, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 1'b0, 5'd3, "R10");
    run(4'd15, 32'h1, 32'h2, 16'h3, 1'b1, 5'd1, "R10");
    // random mix over all codes
    for (int i = 0; i < 600; i++) begin
      logic [3:0] op;
      logic [31:0] a, b;
      op = 4'($urandom_range(0, 15));
      a  = $urandom();
      b  = ($urandom_range(0, 3) == 0) ? a : $urandom();
      run(op, a, b, 16'($urandom()), 1'($urandom()), 5'($urandom()), tag_of(op));
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule